// File: doc/BRIEF.md
# Microcode Sequencer with Pipeline Stall

This block lets a plain in-order pipeline carry out multi-step instructions. The decode stage shows it an opcode together with a valid flag. Most opcodes are simple, and the sequencer lets them go by untouched. A complex opcode is different. The sequencer looks up that opcode's entry point in its control store and loads it into a microprogram counter. From the next clock onward it drives one control word per cycle onto the datapath, and it holds the main pipeline in a stall while it does so.

Every control-store word carries an end-of-sequence flag. On the cycle the flagged word is issued, the stall drops, so the decode stage can move in that same cycle. A complex opcode that arrives in that cycle starts its sequence with no idle gap. In the default configuration there are four sequences, and sequence number k is k+1 words long. The control store is filled back to back, so sequence k begins at address k(k+1)/2. The word at address a carries the control value a+1, which keeps every issued word distinct from the no-operation value of zero.

Top module: `ucode_seq`

## Requirements
- R1: After reset `busy_o` and `stall_o` are 0 and `ctl_o` is the no-operation word 0.
- R2: An opcode is complex only when its top bit is 1 and its remaining bits, read as an unsigned number k, are below NUM_SEQ (4). Any other opcode, including one with the top bit set and k of NUM_SEQ or more, leaves `busy_o` at 0 and `ctl_o` at 0.
- R3: A complex opcode presented with `dec_valid_i` high while `stall_o` is 0 is taken at that clock edge. From the next cycle `busy_o` is 1 and `ctl_o` equals k(k+1)/2 + 1.
- R4: Each later clock advances the sequence by one word, so `ctl_o` rises by 1. Sequence k issues exactly k+1 words.
- R5: `stall_o` is 1 for every word of a sequence except the last, and 0 on the cycle the last word is issued.
- R6: On the clock after the last word, if no new request is taken, the unit returns to idle: `busy_o` is 0 and `ctl_o` is 0.
- R7: A complex request presented while `stall_o` is 1 is ignored, and the running sequence continues unchanged.
- R8: A complex request presented during the last-word cycle is taken, and its first word follows on the very next cycle.
- R9: A complex opcode with `dec_valid_i` at 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid_i | input | 1 | Decode stage holds a valid opcode |
| dec_op_i | input | OP_W (4) | Opcode from the decode stage |
| stall_o | output | 1 | Holds the main pipeline |
| ctl_o | output | CW_W (8) | Control word for the datapath, 0 when idle |
| busy_o | output | 1 | A microsequence is issuing |

## Verification
The assertions assume that a request which arrives while the stall is high does not need to be remembered. They also assume that the opcode input only has to be meaningful when the valid flag is high. The stimulus sweeps every opcode value, with the valid flag both low and high. It also pushes competing complex requests against an active stall, and it issues a new request exactly in the release cycle, so that the assumed behaviour is exercised at both edges.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

   typedef enum logic {SEQ_IDLE = 1'b0, SEQ_RUN = 1'b1} seq_state_e;

   // first control-store address of sequence k (sequences packed back to back)
   function automatic int tri_start(input int k);
      return (k * (k + 1)) / 2;
   endfunction

   // true when address a holds the final word of some sequence
   function automatic bit is_seq_end(input int a, input int n_seq);
      for (int k = 0; k < n_seq; k++)
         if (a == tri_start(k) + k) return 1'b1;
      return 1'b0;
   endfunction

endpackage

// File: rtl/ucode_map.sv
module ucode_map
   import ucode_pkg::*;
#(
   parameter int OP_W    = 4,
   parameter int ADDR_W  = 4,
   parameter int NUM_SEQ = 4
)(
   input  logic [OP_W-1:0]   op_i,
   output logic              cplx_o,
   output logic [ADDR_W-1:0] start_o
);
   localparam int IDX_W = OP_W - 1;

   logic [IDX_W-1:0] idx;
   assign idx = op_i[IDX_W-1:0];

   always_comb begin
      cplx_o  = op_i[OP_W-1] && (int'(idx) < NUM_SEQ);
      start_o = '0;
      if (cplx_o) start_o = ADDR_W'(tri_start(int'(idx)));
   end
endmodule

// File: rtl/ucode_rom.sv
module ucode_rom
   import ucode_pkg::*;
#(
   parameter int ADDR_W  = 4,
   parameter int CW_W    = 8,
   parameter int NUM_SEQ = 4
)(
   input  logic [ADDR_W-1:0] addr_i,
   output logic [CW_W-1:0]   ctl_o,
   output logic              last_o
);
   localparam int DEPTH = tri_start(NUM_SEQ);

   logic [DEPTH-1:0][CW_W-1:0] ctl_tab;
   logic [DEPTH-1:0]           last_tab;

   for (genvar a = 0; a < DEPTH; a++) begin : g_word
      assign ctl_tab[a]  = CW_W'(a + 1);
      assign last_tab[a] = is_seq_end(a, NUM_SEQ);
   end

   always_comb begin
      ctl_o  = '0;
      last_o = 1'b1;   // any address past the table ends the sequence
      if (int'(addr_i) < DEPTH) begin
         ctl_o  = ctl_tab[addr_i];
         last_o = last_tab[addr_i];
      end
   end
endmodule

// File: rtl/ucode_ctr.sv
module ucode_ctr
   import ucode_pkg::*;
#(
   parameter int ADDR_W = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] start_i,
   input  logic              last_i,
   output logic              busy_o,
   output logic              stall_o,
   output logic [ADDR_W-1:0] addr_o
);
   seq_state_e        state_q;
   logic [ADDR_W-1:0] addr_q;
   logic              take;

   assign busy_o  = (state_q == SEQ_RUN);
   assign stall_o = busy_o & ~last_i;
   assign take    = req_i & ~stall_o;
   assign addr_o  = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         addr_q  <= '0;
      end else if (take) begin
         state_q <= SEQ_RUN;
         addr_q  <= start_i;
      end else if (busy_o && last_i) begin
         state_q <= SEQ_IDLE;
      end else if (busy_o) begin
         addr_q <= addr_q + 1'b1;
      end
   end

   a_r3_load_start: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> busy_o && addr_o == $past(start_i));
   a_r4_step_next: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o |=> busy_o && addr_o == $past(addr_o) + 1'b1);
   a_r6_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && last_i && !req_i |=> !busy_o);
   a_r2_no_spurious_start: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !req_i |=> !busy_o);
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
   import ucode_pkg::*;
#(
   parameter int OP_W    = 4,
   parameter int ADDR_W  = 4,
   parameter int CW_W    = 8,
   parameter int NUM_SEQ = 4
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dec_valid_i,
   input  logic [OP_W-1:0] dec_op_i,
   output logic            stall_o,
   output logic [CW_W-1:0] ctl_o,
   output logic            busy_o
);
   localparam int DEPTH = tri_start(NUM_SEQ);

   if (OP_W < 2) begin : g_bad_op
      $error("OP_W must be at least 2");
   end
   if (NUM_SEQ < 1 || NUM_SEQ > (1 << (OP_W - 1))) begin : g_bad_seq
      $error("NUM_SEQ must fit the opcode index field");
   end
   if (DEPTH > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the control store");
   end
   if (DEPTH >= (1 << CW_W)) begin : g_bad_cw
      $error("CW_W too narrow for distinct control words");
   end

   logic              cplx;
   logic [ADDR_W-1:0] start_addr;
   logic [ADDR_W-1:0] upc;
   logic [CW_W-1:0]   rom_ctl;
   logic              rom_last;

   ucode_map #(.OP_W(OP_W), .ADDR_W(ADDR_W), .NUM_SEQ(NUM_SEQ)) u_map (
      .op_i(dec_op_i), .cplx_o(cplx), .start_o(start_addr));

   ucode_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .req_i(dec_valid_i & cplx),
      .start_i(start_addr), .last_i(rom_last),
      .busy_o(busy_o), .stall_o(stall_o), .addr_o(upc));

   ucode_rom #(.ADDR_W(ADDR_W), .CW_W(CW_W), .NUM_SEQ(NUM_SEQ)) u_rom (
      .addr_i(upc), .ctl_o(rom_ctl), .last_o(rom_last));

   assign ctl_o = busy_o ? rom_ctl : '0;

   a_r3_start_in_store: assert property (@(posedge clk) disable iff (!rst_n)
      cplx |-> int'(start_addr) < DEPTH);
   a_r4_word_not_nop: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> ctl_o != '0);
endmodule

// File: tb/tb_ucode_seq.sv
module tb_ucode_seq;
   localparam int OP_W = 4, CW_W = 8, NSEQ = 4;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            dec_valid_i;
   logic [OP_W-1:0] dec_op_i;
   logic            stall_o, busy_o;
   logic [CW_W-1:0] ctl_o;

   int n_run = 0, n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   ucode_seq dut (.clk(clk), .rst_n(rst_n), .dec_valid_i(dec_valid_i),
      .dec_op_i(dec_op_i), .stall_o(stall_o), .ctl_o(ctl_o), .busy_o(busy_o));

   function automatic int exp_start(input int k);
      return k * (k + 1) / 2;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle_checks(input string req);
      check(req, busy_o, 0);
      check(req, stall_o, 0);
      check(req, ctl_o, 0);
   endtask

   // request sequence k; optionally push a rival request while stalled,
   // optionally chain sequence nk on the last word
   task automatic run_seq(input int k, input bit rival, input int nk);
      dec_valid_i = 1'b1;
      dec_op_i    = OP_W'(8 + k);
      @(negedge clk);
      for (int j = 0; j <= k; j++) begin
         check("R3/R4 word", ctl_o, exp_start(k) + j + 1);
         check("R3 busy", busy_o, 1);
         check("R5 stall", stall_o, (j != k) ? 1 : 0);
         if (j != k && rival) begin
            dec_valid_i = 1'b1;                     // R7 rival request
            dec_op_i    = OP_W'(8 + ((k + 1) % NSEQ));
         end else if (j == k && nk >= 0) begin
            dec_valid_i = 1'b1;                     // R8 chained request
            dec_op_i    = OP_W'(8 + nk);
         end else begin
            dec_valid_i = 1'b0;
         end
         @(negedge clk);
      end
      dec_valid_i = 1'b0;
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; dec_valid_i = 1'b0; dec_op_i = '0;
      repeat (3) @(negedge clk);
      idle_checks("R1");
      rst_n = 1'b1;
      @(negedge clk);
      idle_checks("R1");

      // R2 / R9: sweep every opcode, valid low then valid high for simple ones
      for (int op = 0; op < 16; op++) begin
         dec_valid_i = 1'b0; dec_op_i = OP_W'(op);
         @(negedge clk);
         @(negedge clk);
         idle_checks("R9");
         if (!(op >= 8 && op - 8 < NSEQ)) begin
            dec_valid_i = 1'b1;
            @(negedge clk);
            dec_valid_i = 1'b0;
            idle_checks("R2");
         end
      end

      // R3 R4 R5 R6: each sequence alone
      for (int k = 0; k < NSEQ; k++) begin
         run_seq(k, 1'b0, -1);
         idle_checks("R6");
      end

      // R7: rival requests during stall are ignored
      for (int k = 1; k < NSEQ; k++) begin
         run_seq(k, 1'b1, -1);
         idle_checks("R7/R6");
      end

      // R8: back-to-back chaining
      run_seq(2, 1'b0, 3);
      for (int j = 0; j <= 3; j++) begin
         check("R8 chained word", ctl_o, exp_start(3) + j + 1);
         check("R8 stall", stall_o, (j != 3) ? 1 : 0);
         dec_valid_i = 1'b0;
         if (j == 3) begin dec_valid_i = 1'b1; dec_op_i = OP_W'(8); end
         @(negedge clk);
      end
      dec_valid_i = 1'b0;
      check("R8 len1 chained", ctl_o, 1);
      check("R8 len1 stall", stall_o, 0);
      @(negedge clk);
      idle_checks("R6");

      // R1 again: reset mid-sequence
      dec_valid_i = 1'b1; dec_op_i = OP_W'(11);
      @(negedge clk);
      dec_valid_i = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      idle_checks("R1");
      rst_n = 1'b1;

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule